// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the low two address bits for a four-beat burst in a synchronous burst memory. When a new external address is accepted, the block captures the whole address. The two low bits become the starting offset of the burst and the beat index returns to zero. Each advance request moves the burst one beat forward. The next offset comes from one of two orderings. A static ordering input picks either an interleaved pattern, where each offset is the start XOR the beat index, or a linear pattern, where each step adds one modulo four.

When neither a load nor an advance is requested, the block holds its position. The upper address bits are those captured at the last load, and advancing never changes them. The outputs are the full current address and the beat index, both registered. A memory controller drives `load` when it accepts an external address and drives `adv` on each burst continuation. It then reads `addr_out` for the array address.

Top module: `burst_addr_seq`

## Requirements
- R1: A clock edge with `rst` high sets `beat` to 0 and `addr_out` to all zeros.
- R2: A clock edge with `load` high makes `addr_out` equal the `addr_in` sampled at that edge and sets `beat` to 0. This holds whatever the burst position was.
- R3: With `mode_interleave` = 0 (linear ordering), the offset `addr_out[1:0]` after an advance equals (start + `beat`) mod 4. For a start of 10 the offsets are 10, 11, 00, 01.
- R4: With `mode_interleave` = 1 (interleaved ordering), the offset `addr_out[1:0]` after an advance equals start XOR `beat`. A start of 01 gives 01, 00, 11, 10, and a start of 11 gives 11, 10, 01, 00.
- R5: Each advance adds one to `beat` modulo 4. After the fourth beat, further advances repeat the same four-offset pattern.
- R6: A clock edge with `load` and `adv` both low leaves `addr_out` and `beat` unchanged.
- R7: `addr_out[ADDR_W-1:2]` always equals the upper bits of the address captured at the last load, or zero since reset. An advance never changes them.
- R8: When `load` and `adv` are both high, the load takes effect and the advance is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_interleave | input | 1 | Ordering select: 1 interleaved, 0 linear |
| load | input | 1 | Accept a new external address |
| addr_in | input | ADDR_W | External address to load |
| adv | input | 1 | Advance to the next beat |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Current beat index, 0 to 3 |

## Verification
The bench walks each ordering from every start value. It then keeps advancing past the fourth beat. A sequencer that saturated or cleared its beat count at that point would stop early or jump back to the start offset. Simultaneous load and advance are tested to catch a design that lets the advance win, since that design would come out one beat off the loaded address. The bench also reloads in the middle of a burst, to catch a design that keeps the old beat count. Suspend cycles and random traffic with upper-bit changes expose a design that drifts the offset while no advance is requested, or that lets the low-bit carry spill into the upper address bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;
    localparam int BURST_LEN = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        ofs_t start;
        ofs_t beat;
        ofs_t ofs;
    } burst_state_t;

    function automatic ofs_t beat_offset(order_e order, ofs_t start, ofs_t beat);
        ofs_t r;
        if (order == ORDER_INTERLEAVE) begin
            r = start ^ beat;
        end else begin
            r = ofs_t'(start + beat);
        end
        return r;
    endfunction

endpackage

// File: rtl/burst_order_unit.sv
module burst_order_unit
    import burst_seq_pkg::*;
(
    input  order_e       order,
    input  logic         load,
    input  logic         adv,
    input  ofs_t         load_ofs,
    input  burst_state_t cur,
    output burst_state_t nxt
);

    ofs_t beat_inc;

    always_comb begin
        beat_inc = ofs_t'(cur.beat + 1'b1);
        nxt = cur;
        if (load) begin
            nxt.start = load_ofs;
            nxt.beat  = '0;
            nxt.ofs   = load_ofs;
        end else if (adv) begin
            nxt.beat = beat_inc;
            nxt.ofs  = beat_offset(order, cur.start, beat_inc);
        end
    end

endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  burst_state_t nxt,
    output burst_state_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UP_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UP_W-1:0] upper_in,
    output logic [UP_W-1:0] upper_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_out <= '0;
        end else if (load) begin
            upper_out <= upper_in;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_interleave,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);

    localparam int UP_W = ADDR_W - OFS_W;

    order_e       order;
    burst_state_t cur_st;
    burst_state_t nxt_st;
    logic [UP_W-1:0] upper_q;

    assign order = order_e'(mode_interleave);

    burst_order_unit u_order (
        .order    (order),
        .load     (load),
        .adv      (adv),
        .load_ofs (addr_in[OFS_W-1:0]),
        .cur      (cur_st),
        .nxt      (nxt_st)
    );

    burst_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    burst_upper_reg #(.UP_W(UP_W)) u_upper (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .upper_in  (addr_in[ADDR_W-1:OFS_W]),
        .upper_out (upper_q)
    );

    assign addr_out = {upper_q, cur_st.ofs};
    assign beat     = cur_st.beat;

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat == '0));

    // R2, R8
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr_out == $past(addr_in) && beat == '0));

    // R3
    assert_linear_order_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !mode_interleave) |=> (addr_out[1:0] == ofs_t'(cur_st.start + beat)));

    // R4
    assert_interleave_order_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && mode_interleave) |=> (addr_out[1:0] == (cur_st.start ^ beat)));

    // R5
    assert_beat_step_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (beat == ofs_t'($past(beat) + 1'b1)));

    // R6
    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> ($stable(addr_out) && $stable(beat)));

    // R7
    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(addr_out[ADDR_W-1:OFS_W]));

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_interleave;
    logic          load;
    logic [AW-1:0] addr_in;
    logic          adv;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [1:0]    m_start;
    logic [1:0]    m_beat;
    logic [AW-1:0] m_addr;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk             (clk),
        .rst             (rst),
        .mode_interleave (mode_interleave),
        .load            (load),
        .addr_in         (addr_in),
        .adv             (adv),
        .addr_out        (addr_out),
        .beat            (beat)
    );

    function automatic logic [1:0] exp_ofs(logic inter, logic [1:0] s, logic [1:0] b);
        if (inter) return s ^ b;
        return 2'(s + b);
    endfunction

    task automatic check(string req, logic [AW-1:0] ea, logic [1:0] eb);
        n_checks++;
        if (addr_out !== ea || beat !== eb) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                     req, addr_out, beat, ea, eb);
        end
    endtask

    // one clock: drive at negedge, model update, sample 1ns after posedge
    task automatic cyc(string req, logic ld, logic av, logic md, logic [AW-1:0] a);
        @(negedge clk);
        rst = 1'b0; load = ld; adv = av; mode_interleave = md; addr_in = a;
        if (ld) begin
            m_start = a[1:0];
            m_beat  = 2'd0;
            m_addr  = a;
        end else if (av) begin
            m_beat = 2'(m_beat + 1);
            m_addr[1:0] = exp_ofs(md, m_start, m_beat);
        end
        @(posedge clk);
        #1;
        check(req, m_addr, m_beat);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; load = 1'b0; adv = 1'b0; mode_interleave = 1'b1; addr_in = '0;
        m_start = 2'd0; m_beat = 2'd0; m_addr = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", '0, 2'd0);

        // R3 linear from 10, run past four beats
        cyc("R2 load", 1'b1, 1'b0, 1'b0, 16'hA5A2);
        for (int i = 0; i < 6; i++) cyc("R3 linear", 1'b0, 1'b1, 1'b0, 16'h0000);
        // R4 interleaved from 01 and 11
        cyc("R2 load", 1'b1, 1'b0, 1'b1, 16'h1231);
        for (int i = 0; i < 5; i++) cyc("R4 interleave 01", 1'b0, 1'b1, 1'b1, 16'hFFFF);
        cyc("R2 load", 1'b1, 1'b0, 1'b1, 16'h4443);
        for (int i = 0; i < 3; i++) cyc("R4 interleave 11", 1'b0, 1'b1, 1'b1, 16'h0000);
        // R5 wrap beyond fourth beat
        for (int i = 0; i < 4; i++) cyc("R5 wrap", 1'b0, 1'b1, 1'b1, 16'h0000);
        // R6 suspend
        for (int i = 0; i < 3; i++) cyc("R6 suspend", 1'b0, 1'b0, 1'b1, 16'hBEEF);
        // R2 reload mid-burst, R8 load beats advance
        cyc("R3 linear", 1'b0, 1'b1, 1'b0, 16'h0000);
        cyc("R8 load with adv", 1'b1, 1'b1, 1'b0, 16'h7F02);
        cyc("R2 reload mid-burst", 1'b0, 1'b1, 1'b0, 16'h0000);
        cyc("R2 reload mid-burst", 1'b1, 1'b0, 1'b1, 16'h0003);
        // R7 upper unchanged across many advances
        for (int i = 0; i < 8; i++) cyc("R7 upper hold", 1'b0, 1'b1, 1'(i), 16'hFFFF);

        // all starts in both orderings
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc("R2 load", 1'b1, 1'b0, 1'(md), 16'(16'h3C00 | s));
                for (int k = 0; k < 4; k++)
                    cyc(md != 0 ? "R4 sweep" : "R3 sweep", 1'b0, 1'b1, 1'(md), 16'h0000);
            end
        end

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic ld, av, md;
            ld = ($urandom % 6) == 0;
            av = ($urandom % 3) != 0;
            md = ($urandom % 8) != 0;
            cyc("R5 random", ld, av, md, 16'($urandom));
        end

        // R1 reset mid-burst
        @(negedge clk);
        rst = 1'b1; load = 1'b0; adv = 1'b1;
        @(posedge clk);
        #1;
        m_start = 2'd0; m_beat = 2'd0; m_addr = '0;
        check("R1 reset mid-burst", '0, 2'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule